// File: doc/BRIEF.md
# Full-Line Write Promotion Controller

This block sits in front of a small first-level line store and decides how each write from the CPU side is handled. If fast writes are enabled, a write that covers exactly one whole line and starts on a line boundary is turned into a write-invalidate. The block puts that line into its store at once and fills it with the request data. It then sends the data on to memory as a write, with no read for ownership. Every other write goes around the store to memory. A local copy of the line that such a write targets is dropped.

A line filled this way is held dirty and not writable until memory sends the write-invalidate response. A "may become exclusive" flag is set at fill time and cleared by a read snoop. When the response arrives, this flag decides whether the line ends exclusive or shared. The request port holds off two kinds of write until an outstanding write-invalidate completes. The first is a write that meets a line whose flag is still set. The second is a promoted write that finds no replaceable line. Any write-invalidate response releases that hold. The CPU side only ever sees a plain write acknowledge. Reads of the store return hit, exclusive and data, so the line state can be observed.

Top module: `lineWritePromoter`

## Requirements
- R1: An accepted write produces exactly one memory request in the next cycle. It carries the address, size and data of the write. It stays valid and unchanged until `memReqReady` is high. There is no read command on the memory port.
- R2: A write is promoted (`memReqInv`=1) only if `fastWriteEn`=1, `cpuReqSize` equals LINE_BYTES and the address bits below the line size are zero. Any other write is sent with `memReqInv`=0.
- R3: A promoted write fills its line at acceptance. A read of that line before the response returns hit=1, the written data and exclusive=0.
- R4: If no read snoop hits the line between fill and response, the line reads back afterwards with hit=1 and exclusive=1.
- R5: If a read snoop (`snoopValid`=1, `snoopInv`=0) hits the line before the response, the line reads back afterwards with hit=1 and exclusive=0.
- R6: A write to a present line whose line still awaits its write-invalidate response and has not been snooped is refused (`cpuReqReady`=0). The port then stays not ready until a write-invalidate response arrives. After that, the same write is accepted.
- R7: A promoted write for which every line is awaiting a response is refused in the same way. Once a response arrives, it replaces a line that has no outstanding write-invalidate.
- R8: If a snoop invalidate (`snoopInv`=1) removes the line first, the later write-invalidate response changes no line: the address still reads as a miss.
- R9: Each memory response, of either kind, gives a one-cycle `cpuWrAck` in the following cycle. There is no separate write-invalidate acknowledge.
- R10: An accepted write that is not promoted removes any local copy of its line, so a later read misses.
- R11: After reset, `cpuReqReady`=1, `memReqValid`=0, `cpuWrAck`=0, `cpuRdValid`=0, and any read misses.
- R12: An accepted read gives `cpuRdValid`=1 in the next cycle, with hit, exclusive and data for the addressed line (data 0 on a miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastWriteEn | input | 1 | Enables promotion of full aligned writes |
| cpuReqValid | input | 1 | CPU request valid |
| cpuReqReady | output | 1 | CPU request accepted when high with valid |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Byte address |
| cpuReqSize | input | $clog2(LINE_BYTES)+1 | Write size in bytes |
| cpuReqData | input | 8*LINE_BYTES | Write data |
| cpuWrAck | output | 1 | Write acknowledge pulse |
| cpuRdValid | output | 1 | Read result valid |
| cpuRdHit | output | 1 | Read found the line |
| cpuRdExcl | output | 1 | Line found is writable (exclusive) |
| cpuRdData | output | 8*LINE_BYTES | Line data |
| memReqValid | output | 1 | Memory write request valid |
| memReqReady | input | 1 | Memory takes the request |
| memReqInv | output | 1 | 1 = write-invalidate, 0 = plain write |
| memReqAddr | output | ADDR_W | Request address |
| memReqSize | output | $clog2(LINE_BYTES)+1 | Request size in bytes |
| memReqData | output | 8*LINE_BYTES | Request data |
| memRespValid | input | 1 | Memory response valid |
| memRespInv | input | 1 | Response is for a write-invalidate |
| memRespAddr | input | ADDR_W | Response address |
| snoopValid | input | 1 | Snoop from another cache |
| snoopInv | input | 1 | 1 = invalidating snoop, 0 = read snoop |
| snoopAddr | input | ADDR_W | Snoop address |

## Verification
A wrong status bit becomes visible on the next read of that line. If the exclusive flag was lost or kept wrongly, the read after the response shows the wrong exclusive value in the cycle after it is accepted. If a fill or a drop went wrong, the read shows the wrong hit bit. A hold that is never set lets a conflicting write through in one cycle, and a hold that is never released shows up as a port that stays not ready. A wrong promotion decision shows as a wrong `memReqInv` one cycle after acceptance.

// File: rtl/lwpPkg.sv
package lwpPkg;
  typedef struct packed {
    logic valid;
    logic readable;
    logic writable;
    logic dirty;
    logic mayExcl;
  } lineStat_t;

  typedef struct packed {
    logic fill;
    logic dropHit;
    logic respApply;
    logic snoopShare;
    logic snoopKill;
  } lineStrobe_t;
endpackage

// File: rtl/lwpDatapath.sv
module lwpDatapath import lwpPkg::*; #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 14,
  parameter int LINE_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strobes,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [LINE_W-1:0] reqData,
  input  logic [TAG_W-1:0]  respTag,
  input  logic [TAG_W-1:0]  snoopTag,
  output logic              reqHit,
  output lineStat_t         reqStat,
  output logic [LINE_W-1:0] reqRdData,
  output logic              allocOk
);
  localparam int IDX_W = $clog2(NUM_LINES);

  lineStat_t         stat     [NUM_LINES];
  lineStat_t         statNext [NUM_LINES];
  logic [TAG_W-1:0]  tagMem   [NUM_LINES];
  logic [LINE_W-1:0] dataMem  [NUM_LINES];
  logic [IDX_W-1:0]  rrPtr, reqIdx, respIdx, snIdx, victimIdx;
  logic              respHit, snHit;
  logic [NUM_LINES-1:0] pendVec;

  always_comb begin
    reqHit = 1'b0; reqIdx = '0;
    respHit = 1'b0; respIdx = '0;
    snHit = 1'b0; snIdx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      pendVec[i] = stat[i].valid && stat[i].dirty && !stat[i].writable;
      if (!reqHit && stat[i].valid && tagMem[i] == reqTag) begin
        reqHit = 1'b1; reqIdx = i[IDX_W-1:0];
      end
      if (!respHit && pendVec[i] && tagMem[i] == respTag) begin
        respHit = 1'b1; respIdx = i[IDX_W-1:0];
      end
      if (!snHit && stat[i].valid && tagMem[i] == snoopTag) begin
        snHit = 1'b1; snIdx = i[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    victimIdx = '0;
    if (reqHit) begin
      found = !pendVec[reqIdx];
      victimIdx = reqIdx;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (!found && !stat[i].valid) begin
          found = 1'b1; victimIdx = i[IDX_W-1:0];
        end
      end
      for (int k = 0; k < NUM_LINES; k++) begin
        if (!found && !pendVec[rrPtr + k[IDX_W-1:0]]) begin
          found = 1'b1; victimIdx = rrPtr + k[IDX_W-1:0];
        end
      end
    end
    allocOk = found;
  end

  assign reqStat   = reqHit ? stat[reqIdx] : '0;
  assign reqRdData = reqHit ? dataMem[reqIdx] : '0;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      statNext[i] = stat[i];
      if (strobes.fill && victimIdx == i[IDX_W-1:0])
        statNext[i] = '{valid: 1'b1, readable: 1'b1, writable: 1'b0, dirty: 1'b1, mayExcl: 1'b1};
      if (strobes.dropHit && reqHit && reqIdx == i[IDX_W-1:0])
        statNext[i] = '0;
      if (strobes.respApply && respHit && respIdx == i[IDX_W-1:0]) begin
        statNext[i].writable = statNext[i].mayExcl;
        statNext[i].dirty    = 1'b0;
        statNext[i].mayExcl  = 1'b0;
      end
      if (strobes.snoopShare && snHit && snIdx == i[IDX_W-1:0]) begin
        statNext[i].writable = 1'b0;
        statNext[i].mayExcl  = 1'b0;
      end
      if (strobes.snoopKill && snHit && snIdx == i[IDX_W-1:0])
        statNext[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        stat[i]    <= '0;
        tagMem[i]  <= '0;
        dataMem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_LINES; i++) stat[i] <= statNext[i];
      if (strobes.fill) begin
        tagMem[victimIdx]  <= reqTag;
        dataMem[victimIdx] <= reqData;
        rrPtr              <= rrPtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lwpControl.sv
module lwpControl import lwpPkg::*; #(
  parameter int LINE_BYTES = 4,
  parameter int ADDR_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fastWriteEn,
  input  logic                cpuReqValid,
  output logic                cpuReqReady,
  input  logic                cpuReqWrite,
  input  logic [ADDR_W-1:0]   cpuReqAddr,
  input  logic [$clog2(LINE_BYTES):0] cpuReqSize,
  input  logic [8*LINE_BYTES-1:0] cpuReqData,
  output logic                cpuWrAck,
  output logic                cpuRdValid,
  output logic                cpuRdHit,
  output logic                cpuRdExcl,
  output logic [8*LINE_BYTES-1:0] cpuRdData,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic                memReqInv,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [$clog2(LINE_BYTES):0] memReqSize,
  output logic [8*LINE_BYTES-1:0] memReqData,
  input  logic                memRespValid,
  input  logic                memRespInv,
  input  logic                snoopValid,
  input  logic                snoopInv,
  input  logic                reqHit,
  input  lineStat_t           reqStat,
  input  logic [8*LINE_BYTES-1:0] reqRdData,
  input  logic                allocOk,
  output lineStrobe_t         strobes,
  output logic                blockedQ
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SIZE_W = OFF_W + 1;

  logic promote, pendingHit, refuse, idle, accept;

  assign promote    = cpuReqWrite && fastWriteEn &&
                      (cpuReqSize == SIZE_W'(LINE_BYTES)) &&
                      (cpuReqAddr[OFF_W-1:0] == '0);
  assign pendingHit = reqHit && reqStat.dirty && !reqStat.writable;
  assign refuse     = cpuReqWrite &&
                      ((reqHit && reqStat.mayExcl) || (promote && (pendingHit || !allocOk)));
  assign idle        = !blockedQ && !memReqValid;
  assign cpuReqReady = idle && !refuse;
  assign accept      = cpuReqValid && cpuReqReady;

  always_comb begin
    strobes            = '0;
    strobes.fill       = accept && promote;
    strobes.dropHit    = accept && cpuReqWrite && !promote && reqHit;
    strobes.respApply  = memRespValid && memRespInv;
    strobes.snoopShare = snoopValid && !snoopInv;
    strobes.snoopKill  = snoopValid && snoopInv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockedQ    <= 1'b0;
      memReqValid <= 1'b0;
      memReqInv   <= 1'b0;
      memReqAddr  <= '0;
      memReqSize  <= '0;
      memReqData  <= '0;
      cpuWrAck    <= 1'b0;
      cpuRdValid  <= 1'b0;
      cpuRdHit    <= 1'b0;
      cpuRdExcl   <= 1'b0;
      cpuRdData   <= '0;
    end else begin
      if (memRespValid && memRespInv)           blockedQ <= 1'b0;
      else if (cpuReqValid && idle && refuse)   blockedQ <= 1'b1;

      if (accept && cpuReqWrite) begin
        memReqValid <= 1'b1;
        memReqInv   <= promote;
        memReqAddr  <= cpuReqAddr;
        memReqSize  <= cpuReqSize;
        memReqData  <= cpuReqData;
      end else if (memReqReady) begin
        memReqValid <= 1'b0;
      end

      cpuWrAck   <= memRespValid;
      cpuRdValid <= accept && !cpuReqWrite;
      if (accept && !cpuReqWrite) begin
        cpuRdHit  <= reqHit && reqStat.valid && reqStat.readable;
        cpuRdExcl <= reqHit && reqStat.writable;
        cpuRdData <= reqRdData;
      end
    end
  end
endmodule

// File: rtl/lineWritePromoter.sv
module lineWritePromoter import lwpPkg::*; #(
  parameter int LINE_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fastWriteEn,
  input  logic                cpuReqValid,
  output logic                cpuReqReady,
  input  logic                cpuReqWrite,
  input  logic [ADDR_W-1:0]   cpuReqAddr,
  input  logic [$clog2(LINE_BYTES):0] cpuReqSize,
  input  logic [8*LINE_BYTES-1:0] cpuReqData,
  output logic                cpuWrAck,
  output logic                cpuRdValid,
  output logic                cpuRdHit,
  output logic                cpuRdExcl,
  output logic [8*LINE_BYTES-1:0] cpuRdData,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic                memReqInv,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [$clog2(LINE_BYTES):0] memReqSize,
  output logic [8*LINE_BYTES-1:0] memReqData,
  input  logic                memRespValid,
  input  logic                memRespInv,
  input  logic [ADDR_W-1:0]   memRespAddr,
  input  logic                snoopValid,
  input  logic                snoopInv,
  input  logic [ADDR_W-1:0]   snoopAddr
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = 8 * LINE_BYTES;

  lineStrobe_t       strobes;
  lineStat_t         reqStat;
  logic              reqHit, allocOk, blockedQ;
  logic [LINE_W-1:0] reqRdData;

  lwpControl #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) uCtl (
    .clk, .rstN, .fastWriteEn, .cpuReqValid, .cpuReqReady, .cpuReqWrite,
    .cpuReqAddr, .cpuReqSize, .cpuReqData, .cpuWrAck, .cpuRdValid, .cpuRdHit,
    .cpuRdExcl, .cpuRdData, .memReqValid, .memReqReady, .memReqInv, .memReqAddr,
    .memReqSize, .memReqData, .memRespValid, .memRespInv, .snoopValid, .snoopInv,
    .reqHit, .reqStat, .reqRdData, .allocOk, .strobes, .blockedQ
  );

  lwpDatapath #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) uDp (
    .clk, .rstN, .strobes,
    .reqTag   (cpuReqAddr[ADDR_W-1:OFF_W]),
    .reqData  (cpuReqData),
    .respTag  (memRespAddr[ADDR_W-1:OFF_W]),
    .snoopTag (snoopAddr[ADDR_W-1:OFF_W]),
    .reqHit, .reqStat, .reqRdData, .allocOk
  );
endmodule

// File: rtl/lwpChecker.sv
module lwpChecker #(
  parameter int LINE_BYTES = 4,
  parameter int ADDR_W     = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                fastWriteEn,
  input logic                cpuReqValid,
  input logic                cpuReqReady,
  input logic                cpuReqWrite,
  input logic                cpuWrAck,
  input logic                cpuRdValid,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic                memReqInv,
  input logic [ADDR_W-1:0]   memReqAddr,
  input logic [8*LINE_BYTES-1:0] memReqData,
  input logic                memRespValid,
  input logic                memRespInv,
  input logic                blockedQ
);
  assert_blocked_stalls_R6: assert property (@(posedge clk) disable iff (!rstN)
    blockedQ |-> !cpuReqReady);

  assert_response_unblocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memRespValid && memRespInv) |=> !blockedQ);

  assert_memreq_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqData) && $stable(memReqInv)));

  assert_write_issues_request_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady && cpuReqWrite) |=> memReqValid);

  assert_no_promotion_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady && cpuReqWrite && !fastWriteEn) |=> !memReqInv);

  assert_ack_follows_response_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRespValid |=> cpuWrAck);

  assert_no_spurious_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memRespValid |=> !cpuWrAck);

  assert_read_timing_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady && !cpuReqWrite) |=> cpuRdValid);
endmodule

bind lineWritePromoter lwpChecker #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .fastWriteEn(fastWriteEn), .cpuReqValid(cpuReqValid),
  .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite), .cpuWrAck(cpuWrAck),
  .cpuRdValid(cpuRdValid), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqInv(memReqInv), .memReqAddr(memReqAddr), .memReqData(memReqData),
  .memRespValid(memRespValid), .memRespInv(memRespInv), .blockedQ(blockedQ)
);

// File: tb/sim_lineWritePromoter.sv
`timescale 1ns/1ps
module sim_lineWritePromoter;
  localparam int LINE_BYTES = 4;
  localparam int ADDR_W     = 16;
  localparam int NUM_LINES  = 4;
  localparam int SIZE_W     = $clog2(LINE_BYTES) + 1;
  localparam int LINE_W     = 8 * LINE_BYTES;

  logic clk = 1'b0, rstN = 1'b0;
  logic fastWriteEn = 1'b1;
  logic cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic [SIZE_W-1:0] cpuReqSize = '0;
  logic [LINE_W-1:0] cpuReqData = '0;
  logic cpuReqReady, cpuWrAck, cpuRdValid, cpuRdHit, cpuRdExcl;
  logic [LINE_W-1:0] cpuRdData;
  logic memReqValid, memReqInv;
  logic memReqReady = 1'b1;
  logic [ADDR_W-1:0] memReqAddr;
  logic [SIZE_W-1:0] memReqSize;
  logic [LINE_W-1:0] memReqData;
  logic memRespValid = 1'b0, memRespInv = 1'b0;
  logic [ADDR_W-1:0] memRespAddr = '0;
  logic snoopValid = 1'b0, snoopInv = 1'b0;
  logic [ADDR_W-1:0] snoopAddr = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lineWritePromoter #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u0 (
    .clk, .rstN, .fastWriteEn, .cpuReqValid, .cpuReqReady, .cpuReqWrite, .cpuReqAddr,
    .cpuReqSize, .cpuReqData, .cpuWrAck, .cpuRdValid, .cpuRdHit, .cpuRdExcl, .cpuRdData,
    .memReqValid, .memReqReady, .memReqInv, .memReqAddr, .memReqSize, .memReqData,
    .memRespValid, .memRespInv, .memRespAddr, .snoopValid, .snoopInv, .snoopAddr
  );

  function automatic bit expPromote(bit en, int size, int addr);
    return en && size == LINE_BYTES && (addr % LINE_BYTES) == 0;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drives a request from a negedge; returns at the negedge after acceptance.
  task automatic sendReq(bit wr, int addr, int size, logic [LINE_W-1:0] data,
                         int maxWait, output bit accepted);
    accepted = 1'b0;
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqAddr = addr[ADDR_W-1:0];
    cpuReqSize = size[SIZE_W-1:0]; cpuReqData = data;
    for (int k = 0; k < maxWait && !accepted; k++) begin
      #1;
      if (cpuReqReady) accepted = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    cpuReqValid = 1'b0;
  endtask

  task automatic readLine(int addr);
    bit acc;
    sendReq(1'b0, addr, 0, '0, 4, acc);
    chk("R12", "read accepted", acc, 1);
    chk("R12", "read valid", cpuRdValid, 1);
  endtask

  task automatic respond(int addr, bit inv);
    memRespValid = 1'b1; memRespInv = inv; memRespAddr = addr[ADDR_W-1:0];
    @(posedge clk); @(negedge clk);
    memRespValid = 1'b0;
    chk("R9", "write ack after response", cpuWrAck, 1);
  endtask

  task automatic snoop(int addr, bit inv);
    snoopValid = 1'b1; snoopInv = inv; snoopAddr = addr[ADDR_W-1:0];
    @(posedge clk); @(negedge clk);
    snoopValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R11", "ready after reset", cpuReqReady, 1);
    chk("R11", "no memory request", memReqValid, 0);
    chk("R11", "no ack", cpuWrAck, 0);
    chk("R11", "no read result", cpuRdValid, 0);
    @(negedge clk);
    readLine(0);
    chk("R11", "empty store misses", cpuRdHit, 0);

    // R2 directed: fast writes disabled, full aligned write stays plain
    fastWriteEn = 1'b0;
    sendReq(1'b1, 'h20, LINE_BYTES, 32'hCAFE0001, 4, acc);
    chk("R2", "disabled write accepted", acc, 1);
    chk("R2", "disabled write not promoted", memReqInv, 0);
    respond('h20, 1'b0);
    readLine('h20);
    chk("R2", "no fill when disabled", cpuRdHit, 0);
    fastWriteEn = 1'b1;

    // Random mix of promoted and plain writes
    for (int it = 0; it < 60; it++) begin
      int addr, size;
      bit en, exp, doSnoop;
      logic [LINE_W-1:0] d;
      size = ($urandom % 2) ? LINE_BYTES : 1 + ($urandom % LINE_BYTES);
      addr = ($urandom % 8) * LINE_BYTES + (($urandom % 3 == 0) ? ($urandom % LINE_BYTES) : 0);
      en = ($urandom % 4) != 0;
      d = $urandom;
      doSnoop = $urandom % 2;
      exp = expPromote(en, size, addr);
      fastWriteEn = en;
      sendReq(1'b1, addr, size, d, 4, acc);
      chk("R1", "random write accepted", acc, 1);
      chk("R1", "memory request valid", memReqValid, 1);
      chk("R1", "memory request address", memReqAddr, addr);
      chk("R1", "memory request size", memReqSize, size);
      chk("R1", "memory request data", memReqData, d);
      chk("R2", "promotion decision", memReqInv, exp);
      if (exp) begin
        if (doSnoop) snoop(addr, 1'b0);
        readLine(addr);
        chk("R3", "filled line hits", cpuRdHit, 1);
        chk("R3", "filled line data", cpuRdData, d);
        chk("R3", "filled line not exclusive", cpuRdExcl, 0);
        respond(addr, 1'b1);
        readLine(addr);
        chk(doSnoop ? "R5" : "R4", "line present after response", cpuRdHit, 1);
        chk(doSnoop ? "R5" : "R4", "final exclusive state", cpuRdExcl, !doSnoop);
      end else begin
        respond(addr, 1'b0);
        readLine(addr);
        chk("R10", "plain write leaves no copy", cpuRdHit, 0);
      end
    end
    fastWriteEn = 1'b1;

    // R6: conflicting write held until the response
    sendReq(1'b1, 'h40, LINE_BYTES, 32'h11112222, 4, acc);
    chk("R6", "promoted write accepted", acc, 1);
    sendReq(1'b1, 'h41, 1, 32'h000000AA, 4, acc);
    chk("R6", "conflicting write refused", acc, 0);
    #1;
    chk("R6", "port stays not ready", cpuReqReady, 0);
    respond('h40, 1'b1);
    sendReq(1'b1, 'h41, 1, 32'h000000AA, 4, acc);
    chk("R6", "write accepted after response", acc, 1);
    chk("R10", "retried write is plain", memReqInv, 0);
    respond('h41, 1'b0);
    readLine('h40);
    chk("R10", "local copy removed", cpuRdHit, 0);

    // R8: line invalidated by snoop before its response
    sendReq(1'b1, 'h80, LINE_BYTES, 32'h55667788, 4, acc);
    chk("R8", "promoted write accepted", acc, 1);
    snoop('h80, 1'b1);
    readLine('h80);
    chk("R8", "invalidated line misses", cpuRdHit, 0);
    respond('h80, 1'b1);
    readLine('h80);
    chk("R8", "response ignored", cpuRdHit, 0);

    // R7: every line awaiting a response
    for (int i = 0; i < NUM_LINES; i++) begin
      sendReq(1'b1, 'h100 + i * LINE_BYTES, LINE_BYTES, 32'hA0 + i, 4, acc);
      chk("R7", "fill of free line accepted", acc, 1);
    end
    sendReq(1'b1, 'h100 + NUM_LINES * LINE_BYTES, LINE_BYTES, 32'hBEEF, 4, acc);
    chk("R7", "no replaceable line refused", acc, 0);
    #1;
    chk("R7", "port stays not ready", cpuReqReady, 0);
    respond('h100, 1'b1);
    sendReq(1'b1, 'h100 + NUM_LINES * LINE_BYTES, LINE_BYTES, 32'hBEEF, 4, acc);
    chk("R7", "accepted after response", acc, 1);
    readLine('h100);
    chk("R7", "completed line was replaced", cpuRdHit, 0);
    readLine('h100 + LINE_BYTES);
    chk("R7", "pending line kept", cpuRdHit, 1);
    chk("R7", "pending line not exclusive", cpuRdExcl, 0);
    readLine('h100 + NUM_LINES * LINE_BYTES);
    chk("R3", "new line data", cpuRdData, 32'hBEEF);
    for (int i = 1; i <= NUM_LINES; i++) respond('h100 + i * LINE_BYTES, 1'b1);
    readLine('h100 + LINE_BYTES);
    chk("R4", "released line exclusive", cpuRdExcl, 1);

    // R1: request held while memory is not ready
    memReqReady = 1'b0;
    sendReq(1'b1, 'h200, 2, 32'h1234, 4, acc);
    repeat (3) @(negedge clk);
    chk("R1", "request held", memReqValid, 1);
    chk("R1", "held address", memReqAddr, 'h200);
    memReqReady = 1'b1;
    @(negedge clk);
    chk("R1", "request retired", memReqValid, 0);
    respond('h200, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule